// File: doc/BRIEF.md
# Privileged System Mask Update Unit

This block is the execute-stage logic for three privileged instructions that rewrite the system-mask field of the processor status word. The clear form turns off the status bits named by a 10-bit immediate. The set form turns them on. The load form copies the whole field from a general register. The clear and set forms also return the old field value to a destination register.

The block decodes the instruction word and checks the privilege level. It moves two immediate bits to their true status-word positions. It refuses a transition that turns the Q flag on while Q is off, and it merges the candidate value into the field only. All results are registered and appear one clock edge after the instruction is presented. An accepted instruction also raises a flush request, so that the pipeline restarts fetch only after pending interrupts have been checked against the new mask.

The register file and the interrupt controller are outside the block. The block only reports the read index it needs and the write it wants to make.

Top module: `smask_exec`

## Requirements
- R1: An instruction is recognised only by these tests: clear when `(insn & 0xFC00FFE0) == 0x00000E60`, set when `(insn & 0xFC00FFE0) == 0x00000D60`, load when `(insn & 0xFFE0FFFF) == 0x00001860`. Any other word produces no update, no write, no flush and no exception.
- R2: The clear form takes its immediate from insn[25:16] and its destination index from insn[4:0]. The new status is the current status with the selected bits cleared inside the field. The destination receives the old field value, with all bits outside the field zero.
- R3: The set form uses the same fields as the clear form. It sets the selected bits inside the field and writes the old field value to the destination.
- R4: The load form reads the source register index from insn[20:16], which is presented on `src_idx_o`. It loads the field from `src_val_i` and performs no register write.
- R5: Immediate bit 8 sets status bit 26, and immediate bit 9 sets status bit 28. Immediate bits 0 to 7 map to status bits 0 to 7. With default parameters the field mask is 0x140000FF.
- R6: Status bits outside the field mask never change on an update.
- R7: At any privilege level other than 0, a recognised and live instruction raises an exception with cause 1 (privileged operation). It then makes no status update, no register write and no flush.
- R8: If the candidate value has Q (bit 3) set while the current status has Q clear, the instruction raises an exception with cause 2 (illegal instruction) and changes no state. The privilege fault takes precedence over this check.
- R9: Every accepted instruction asserts `flush_o` in the same cycle as the status update.
- R10: An invalid or nullified slot has no effect. In every cycle without an update, `psw_o` repeats the `psw_i` value sampled at the previous edge.
- R11: All outputs are registered, with a latency of one clock edge. During reset every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_i | input | 32 | Instruction word |
| valid_i | input | 1 | Slot holds an instruction |
| nullify_i | input | 1 | Instruction is nullified |
| priv_i | input | 2 | Current privilege level, 0 = most privileged |
| psw_i | input | 32 | Current status word |
| src_val_i | input | 32 | Source register value for the load form |
| src_idx_o | output | 5 | Source register index, insn[20:16] |
| psw_o | output | 32 | Next status word |
| psw_upd_o | output | 1 | Status update performed |
| rf_we_o | output | 1 | Destination register write enable |
| rf_idx_o | output | 5 | Destination register index |
| rf_data_o | output | 32 | Destination register data (old field value) |
| exc_o | output | 1 | Exception request |
| exc_cause_o | output | 2 | 1 = privileged operation, 2 = illegal instruction |
| flush_o | output | 1 | Pipeline exit request to re-evaluate interrupts |

## Verification
The bench targets these corner cases:
- Setting immediate bits 8 and 9, which a design without the remap would write to status bits 8 and 9 instead of 26 and 28.
- Turning Q on from both the set form and the load form, where a missing check would let Q rise instead of trapping with cause 2.
- An unprivileged instruction that would also trip the Q check, where the wrong precedence would report cause 2 instead of 1.
- Status words full of bits outside the field, where a full-word merge would corrupt them.
- Nullified, invalid and near-miss encodings, which must leave `psw_o` following `psw_i` with no write or flush.

A long pseudo-random sequence mixes all of these cases back to back.

// File: rtl/smask_pkg.sv
package smask_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_LOAD = 2'd3
  } sm_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PRIV = 2'd1,
    CAUSE_ILL  = 2'd2
  } sm_cause_e;
endpackage

// File: rtl/smask_decode.sv
module smask_decode
  import smask_pkg::*;
#(
  parameter int STAT_BITS = 32,
  parameter int IMM_E_POS = 8,
  parameter int IMM_W_POS = 9,
  parameter int E_POS     = 26,
  parameter int W_POS     = 28
) (
  input  logic [31:0]          insn_i,
  output sm_op_e               op_o,
  output logic [STAT_BITS-1:0] mask_o,
  output logic [4:0]           rd_o,
  output logic [4:0]           rs_o
);
  localparam int IMM_LSB  = 16;
  localparam int IMM_BITS = 10;
  localparam logic [31:0] IMM_FORM_MASK = 32'hFC00FFE0;
  localparam logic [31:0] CLR_PATTERN   = 32'h00000E60;
  localparam logic [31:0] SET_PATTERN   = 32'h00000D60;
  localparam logic [31:0] LOAD_MASK     = 32'hFFE0FFFF;
  localparam logic [31:0] LOAD_PATTERN  = 32'h00001860;

  logic [IMM_BITS-1:0] imm;
  assign imm  = insn_i[IMM_LSB +: IMM_BITS];
  assign rd_o = insn_i[4:0];
  assign rs_o = insn_i[20:16];

  always_comb begin
    if ((insn_i & IMM_FORM_MASK) == CLR_PATTERN)      op_o = OP_CLR;
    else if ((insn_i & IMM_FORM_MASK) == SET_PATTERN) op_o = OP_SET;
    else if ((insn_i & LOAD_MASK) == LOAD_PATTERN)    op_o = OP_LOAD;
    else                                              op_o = OP_NONE;
  end

  // Each immediate bit contributes one status bit. Two of them are relocated.
  logic [IMM_BITS-1:0][STAT_BITS-1:0] part;
  for (genvar k = 0; k < IMM_BITS; k++) begin : g_imm
    localparam int DST = (k == IMM_E_POS) ? E_POS :
                         (k == IMM_W_POS) ? W_POS : k;
    always_comb begin
      part[k]      = '0;
      part[k][DST] = imm[k];
    end
  end

  always_comb begin
    mask_o = '0;
    for (int k = 0; k < IMM_BITS; k++) mask_o = mask_o | part[k];
  end
endmodule

// File: rtl/smask_merge.sv
module smask_merge
  import smask_pkg::*;
#(
  parameter int                   STAT_BITS = 32,
  parameter logic [STAT_BITS-1:0] SM_FIELD  = 32'h140000FF,
  parameter int                   Q_POS     = 3
) (
  input  sm_op_e               op_i,
  input  logic [STAT_BITS-1:0] psw_i,
  input  logic [STAT_BITS-1:0] mask_i,
  input  logic [STAT_BITS-1:0] src_i,
  output logic [STAT_BITS-1:0] next_o,
  output logic                 ill_o,
  output logic [STAT_BITS-1:0] old_sm_o
);
  logic [STAT_BITS-1:0] cand;

  always_comb begin
    unique case (op_i)
      OP_CLR:  cand = psw_i & ~mask_i;
      OP_SET:  cand = psw_i | mask_i;
      OP_LOAD: cand = src_i;
      default: cand = psw_i;
    endcase
  end

  assign ill_o    = cand[Q_POS] & ~psw_i[Q_POS];
  assign next_o   = (psw_i & ~SM_FIELD) | (cand & SM_FIELD);
  assign old_sm_o = psw_i & SM_FIELD;
endmodule

// File: rtl/smask_exec.sv
module smask_exec
  import smask_pkg::*;
#(
  parameter int                   STAT_BITS = 32,
  parameter logic [STAT_BITS-1:0] SM_FIELD  = 32'h140000FF,
  parameter int                   Q_POS     = 3,
  parameter int                   E_POS     = 26,
  parameter int                   W_POS     = 28,
  parameter int                   IMM_E_POS = 8,
  parameter int                   IMM_W_POS = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [31:0]          insn_i,
  input  logic                 valid_i,
  input  logic                 nullify_i,
  input  logic [1:0]           priv_i,
  input  logic [STAT_BITS-1:0] psw_i,
  input  logic [STAT_BITS-1:0] src_val_i,
  output logic [4:0]           src_idx_o,
  output logic [STAT_BITS-1:0] psw_o,
  output logic                 psw_upd_o,
  output logic                 rf_we_o,
  output logic [4:0]           rf_idx_o,
  output logic [STAT_BITS-1:0] rf_data_o,
  output logic                 exc_o,
  output logic [1:0]           exc_cause_o,
  output logic                 flush_o
);
  sm_op_e               op;
  logic [STAT_BITS-1:0] mask, next_psw, old_sm;
  logic [4:0]           rd;
  logic                 ill;

  smask_decode #(
    .STAT_BITS(STAT_BITS), .IMM_E_POS(IMM_E_POS), .IMM_W_POS(IMM_W_POS),
    .E_POS(E_POS), .W_POS(W_POS)
  ) u_dec (
    .insn_i(insn_i), .op_o(op), .mask_o(mask), .rd_o(rd), .rs_o(src_idx_o)
  );

  smask_merge #(
    .STAT_BITS(STAT_BITS), .SM_FIELD(SM_FIELD), .Q_POS(Q_POS)
  ) u_mrg (
    .op_i(op), .psw_i(psw_i), .mask_i(mask), .src_i(src_val_i),
    .next_o(next_psw), .ill_o(ill), .old_sm_o(old_sm)
  );

  logic live, priv_bad, ill_hit, accept;
  sm_cause_e cause;

  assign live     = valid_i & ~nullify_i & (op != OP_NONE);
  assign priv_bad = live & (priv_i != 2'd0);
  assign ill_hit  = live & ~priv_bad & ill;
  assign accept   = live & ~priv_bad & ~ill;
  assign cause    = priv_bad ? CAUSE_PRIV : (ill_hit ? CAUSE_ILL : CAUSE_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_o       <= '0;
      psw_upd_o   <= 1'b0;
      rf_we_o     <= 1'b0;
      rf_idx_o    <= '0;
      rf_data_o   <= '0;
      exc_o       <= 1'b0;
      exc_cause_o <= 2'd0;
      flush_o     <= 1'b0;
    end else begin
      psw_o       <= accept ? next_psw : psw_i;
      psw_upd_o   <= accept;
      rf_we_o     <= accept & (op != OP_LOAD);
      rf_idx_o    <= rd;
      rf_data_o   <= old_sm;
      exc_o       <= priv_bad | ill_hit;
      exc_cause_o <= cause;
      flush_o     <= accept;
    end
  end

  AST_UPD_NEEDS_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_upd_o |-> ($past(priv_i) == 2'd0)); // R7
  AST_OUTSIDE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_upd_o |-> ((psw_o & ~SM_FIELD) == ($past(psw_i) & ~SM_FIELD))); // R6
  AST_EXC_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (!psw_upd_o && !rf_we_o && !flush_o)); // R7
  AST_Q_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_upd_o && !$past(psw_i[Q_POS])) |-> !psw_o[Q_POS]); // R8
  AST_WRITE_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> flush_o); // R9
  AST_IDLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psw_upd_o |-> (psw_o == $past(psw_i))); // R10
endmodule

// File: tb/sim_smask_exec.sv
module sim_smask_exec;
  localparam logic [31:0] SM = 32'h140000FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic        valid = 1'b0, nullify = 1'b0;
  logic [1:0]  priv = '0;
  logic [31:0] psw = '0, src = '0;
  logic [4:0]  src_idx, rf_idx;
  logic [31:0] psw_out, rf_data;
  logic        psw_upd, rf_we, exc, flush;
  logic [1:0]  cause;

  always #4 clk = ~clk;

  smask_exec u0 (
    .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .valid_i(valid),
    .nullify_i(nullify), .priv_i(priv), .psw_i(psw), .src_val_i(src),
    .src_idx_o(src_idx), .psw_o(psw_out), .psw_upd_o(psw_upd),
    .rf_we_o(rf_we), .rf_idx_o(rf_idx), .rf_data_o(rf_data),
    .exc_o(exc), .exc_cause_o(cause), .flush_o(flush)
  );

  typedef struct packed {
    logic [31:0] psw;
    logic        upd;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        exc;
    logic [1:0]  cause;
    logic        flush;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    checks = 0, errors = 0;
  bit    run = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] w_clr(input logic [9:0] imm, input logic [4:0] rt);
    return {6'd0, imm, 16'h0E60 | {11'd0, rt}};
  endfunction
  function automatic logic [31:0] w_set(input logic [9:0] imm, input logic [4:0] rt);
    return {6'd0, imm, 16'h0D60 | {11'd0, rt}};
  endfunction
  function automatic logic [31:0] w_load(input logic [4:0] rs);
    return {11'd0, rs, 16'h1860};
  endfunction

  function automatic exp_t model(input logic [31:0] i, input logic v, input logic n,
                                 input logic [1:0] pv, input logic [31:0] p,
                                 input logic [31:0] s);
    exp_t e;
    logic is_c, is_s, is_l;
    logic [31:0] m, cand;
    e = '0;
    e.psw = p;
    is_c = (i & 32'hFC00FFE0) == 32'h00000E60;
    is_s = (i & 32'hFC00FFE0) == 32'h00000D60;
    is_l = (i & 32'hFFE0FFFF) == 32'h00001860;
    if (!(v && !n && (is_c || is_s || is_l))) return e;
    if (pv != 2'd0) begin
      e.exc = 1'b1; e.cause = 2'd1;
      return e;
    end
    m = {24'd0, i[23:16]};
    if (i[24]) m[26] = 1'b1;
    if (i[25]) m[28] = 1'b1;
    cand = is_c ? (p & ~m) : is_s ? (p | m) : s;
    if (cand[3] && !p[3]) begin
      e.exc = 1'b1; e.cause = 2'd2;
      return e;
    end
    e.psw   = (p & ~SM) | (cand & SM);
    e.upd   = 1'b1;
    e.flush = 1'b1;
    e.we    = !is_l;
    e.idx   = i[4:0];
    e.data  = p & SM;
    return e;
  endfunction

  task automatic drive(input logic [31:0] i, input logic v, input logic n,
                       input logic [1:0] pv, input logic [31:0] p,
                       input logic [31:0] s, input string tag);
    @(negedge clk);
    insn = i; valid = v; nullify = n; priv = pv; psw = p; src = s;
    q.push_back(model(i, v, n, pv, p, s));
    tq.push_back(tag);
  endtask

  // Monitor: compare each registered result one edge after its stimulus (R11)
  initial begin
    exp_t  e;
    string t;
    wait (run);
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        t = tq.pop_front();
        check(psw_out == e.psw, t, "psw_o", psw_out, e.psw);
        check(psw_upd == e.upd, t, "psw_upd_o", {31'd0, psw_upd}, {31'd0, e.upd});
        check(rf_we == e.we, t, "rf_we_o", {31'd0, rf_we}, {31'd0, e.we});
        if (e.we) begin
          check(rf_idx == e.idx, t, "rf_idx_o", {27'd0, rf_idx}, {27'd0, e.idx});
          check(rf_data == e.data, t, "rf_data_o", rf_data, e.data);
        end
        check(exc == e.exc, t, "exc_o", {31'd0, exc}, {31'd0, e.exc});
        if (e.exc) check(cause == e.cause, t, "exc_cause_o", {30'd0, cause}, {30'd0, e.cause});
        check(flush == e.flush, t, "flush_o", {31'd0, flush}, {31'd0, e.flush});
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] pick;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({psw_out, psw_upd, rf_we, rf_idx, rf_data, exc, cause, flush} == '0,
          "R11", "reset outputs", psw_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    run = 1;

    drive(w_clr(10'h00F, 5'd5), 1, 0, 2'd0, 32'hFFFFFFFF, 32'h0, "R2");
    drive(w_set(10'h301, 5'd7), 1, 0, 2'd0, 32'h00000008, 32'h0, "R3/R5");
    drive(w_set(10'h008, 5'd1), 1, 0, 2'd0, 32'h00000000, 32'h0, "R8");
    drive(w_clr(10'h3FF, 5'd31), 1, 0, 2'd0, 32'h1400000F, 32'h0, "R2/R5");
    drive(w_load(5'd9), 1, 0, 2'd0, 32'h00000008, 32'hFFFFFFF7, "R4");
    check(src_idx == 5'd9, "R4", "src_idx_o", {27'd0, src_idx}, 32'd9);
    drive(w_load(5'd2), 1, 0, 2'd3, 32'h00000008, 32'hFFFFFFFF, "R7");
    drive(w_set(10'h008, 5'd1), 1, 0, 2'd1, 32'h00000000, 32'h0, "R7/R8");
    drive(w_clr(10'h0FF, 5'd3), 1, 1, 2'd0, 32'h000000FF, 32'h0, "R10");
    drive(w_set(10'h0FF, 5'd3), 0, 0, 2'd0, 32'h12345670, 32'h0, "R10");
    drive(w_clr(10'h0FF, 5'd3) | 32'h80000000, 1, 0, 2'd0, 32'h000000FF, 32'h0, "R1");
    drive(w_load(5'd4) | 32'h00000001, 1, 0, 2'd0, 32'h00000008, 32'hFFFFFFFF, "R1");
    drive(w_set(10'h0FF, 5'd12), 1, 0, 2'd0, 32'hEBFFFF08, 32'h0, "R6");
    drive(w_load(5'd6), 1, 0, 2'd0, 32'hEBFFFF08, 32'h00000000, "R6/R4");
    drive(w_load(5'd6), 1, 0, 2'd0, 32'h00000000, 32'h00000008, "R8");
    drive(w_set(10'h002, 5'd0), 1, 0, 2'd0, 32'h00000008, 32'h0, "R9");

    r = 32'h1B3C5A7D;
    for (int k = 0; k < 120; k++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      pick = r;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      case (pick[1:0])
        2'd0: drive(w_clr(pick[11:2], pick[16:12]), pick[20] | pick[21], pick[22] & pick[23],
                    (pick[24] & pick[25]) ? pick[27:26] : 2'd0, r, ~r, "R2/R9");
        2'd1: drive(w_set(pick[11:2], pick[16:12]), pick[20] | pick[21], pick[22] & pick[23],
                    (pick[24] & pick[25]) ? pick[27:26] : 2'd0, r, ~r, "R3/R9");
        2'd2: drive(w_load(pick[16:12]), pick[20] | pick[21], pick[22] & pick[23],
                    (pick[24] & pick[25]) ? pick[27:26] : 2'd0, r, {r[15:0], r[31:16]}, "R4/R9");
        default: drive(pick, 1, 0, 2'd0, r, ~r, "R1");
      endcase
    end

    drive(32'h0, 0, 0, 2'd0, 32'hA5A5A5A5, 32'h0, "R10");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule